// File: doc/BRIEF.md
# Register-Programmed Sample Clock Divider

This block derives a square-wave sample clock from a fixed 40 MHz master clock. A host selects one of six output rates (20 MHz, 10 MHz, 4 MHz, 2 MHz, 1 MHz or 400 kHz) by writing a 3-bit rate code into a select register. The write goes through a small parallel port that has four data lines, a 2-bit register address and a write strobe.

A 6-bit down-counter runs on the falling edge of the master clock. Each time it reaches zero, the output flips and the counter reloads with a value taken from the current rate code. The output therefore spends the same number of master cycles high as low.

The strobe is synchronised into the master-clock domain. Its rising edge, together with the address, decides whether the select register takes the low three data bits. A synchronous active-high reset clears the output and the counter. It also restores the rate code that gives 1 MHz.

Top module: `clkrate_gen`

## Requirements
- R1: While `rst` is high, `rate_clk` is 0. On the first falling master edge after `rst` goes low, `rate_clk` goes to 1. After reset the rate code is 3'b100, so each half-period lasts 20 master cycles.
- R2: Rate codes 3'b000, 3'b001, 3'b010, 3'b011 and 3'b100 give half-periods of 1, 2, 5, 10 and 20 master cycles. The matching counter reload values are 0, 1, 4, 9 and 19.
- R3: Rate codes 3'b101, 3'b110 and 3'b111 all give a half-period of 50 master cycles (reload 49). The counter never holds a value above 49.
- R4: `rate_clk` changes only on a falling master edge at which the counter is zero. On every other edge the counter decrements by one. The high and low halves of each period are equal.
- R5: Only a 0-to-1 transition of `reg_strobe` performs a write. Holding the strobe high while the data changes writes nothing more.
- R6: A write with `reg_addr` other than 2'b01 leaves the rate code unchanged.
- R7: A write to address 2'b01 copies `port_data[2:0]` into the rate code. `port_data[3]` is ignored.
- R8: A new rate code takes effect at the next counter reload. The half-period already in progress finishes at the old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all logic advances on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| port_data | input | 4 | Parallel write data; the low three bits carry the rate code |
| reg_addr | input | 2 | Register address; 2'b01 selects the rate register |
| reg_strobe | input | 1 | Write strobe; a write occurs on its rising edge |
| rate_clk | output | 1 | Divided 50% duty-cycle sample clock |

## Verification
The bench measures half-periods in master cycles for every rate code. These measurements would expose a reload off by one, which would stretch every half by a cycle, and a missing saturation of the upper codes, which would produce odd or out-of-range periods. The first half-period after reset is timed as well, so a wrong reset code would show up as a 1 MHz rate that is not 1 MHz.

Writes are aimed at the wrong addresses, carry a stray high data bit, or hold the strobe high while the data changes. A level-sensitive or unmasked write path would then switch the rate when it should not. One write lands in the middle of a long half-period. A design that reloaded the counter immediately would cut that half short instead of finishing it at the old rate.

// File: rtl/clkrate_pkg.sv
package clkrate_pkg;
  localparam int MASTER_HZ = 40_000_000;
  localparam int CNT_W     = 6;
  localparam int SEL_W     = 3;
  localparam int PORT_W    = 4;
  localparam int ADDR_W    = 2;
  localparam logic [SEL_W-1:0]  RESET_CODE = 3'b100;
  localparam logic [ADDR_W-1:0] SEL_ADDR   = 2'b01;

  // Output frequency for each rate code; upper codes saturate to the slowest.
  function automatic int rate_hz(input logic [SEL_W-1:0] code);
    case (code)
      3'd0:    return 20_000_000;
      3'd1:    return 10_000_000;
      3'd2:    return 4_000_000;
      3'd3:    return 2_000_000;
      3'd4:    return 1_000_000;
      default: return 400_000;
    endcase
  endfunction

  // Counter reload = master cycles per half-period minus one.
  function automatic int reload_of(input logic [SEL_W-1:0] code);
    return MASTER_HZ / (2 * rate_hz(code)) - 1;
  endfunction
endpackage

// File: rtl/clkrate_strobe_sync.sv
module clkrate_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic rise
);
  // STAGES synchroniser flops plus one history flop for edge detection.
  logic [STAGES:0] shift_q;

  always_ff @(negedge clk) begin
    if (rst) shift_q <= '0;
    else     shift_q <= {shift_q[STAGES-1:0], strobe};
  end

  assign rise = shift_q[STAGES-1] & ~shift_q[STAGES];
endmodule

// File: rtl/clkrate_sel_reg.sv
module clkrate_sel_reg
  import clkrate_pkg::*;
#(
  parameter int                 DATA_W  = PORT_W,
  parameter int                 CODE_W  = SEL_W,
  parameter int                 AW      = ADDR_W,
  parameter logic [AW-1:0]      MY_ADDR = SEL_ADDR,
  parameter logic [CODE_W-1:0]  INIT    = RESET_CODE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_pulse,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] code
);
  logic wr_hit;
  logic unused_hi;

  assign wr_hit    = wr_pulse && (addr == MY_ADDR);
  assign unused_hi = ^data[DATA_W-1:CODE_W];

  always_ff @(negedge clk) begin
    if (rst)         code <= INIT;
    else if (wr_hit) code <= data[CODE_W-1:0];
  end
endmodule

// File: rtl/clkrate_divider.sv
module clkrate_divider
  import clkrate_pkg::*;
#(
  parameter int CW     = CNT_W,
  parameter int CODE_W = SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  output logic [CW-1:0]     cnt,
  output logic              tick_out
);
  logic [CW-1:0] reload_val;

  assign reload_val = CW'(reload_of(code));

  always_ff @(negedge clk) begin
    if (rst) begin
      cnt      <= '0;
      tick_out <= 1'b0;
    end else if (cnt == '0) begin
      cnt      <= reload_val;
      tick_out <= ~tick_out;
    end else begin
      cnt      <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/clkrate_gen.sv
module clkrate_gen
  import clkrate_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] port_data,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_strobe,
  output logic              rate_clk
);
  logic             wr_pulse;
  logic [SEL_W-1:0] sel_code;
  logic [CNT_W-1:0] div_cnt;

  clkrate_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .strobe (reg_strobe),
    .rise   (wr_pulse)
  );

  clkrate_sel_reg u_sel (
    .clk      (clk),
    .rst      (rst),
    .wr_pulse (wr_pulse),
    .addr     (reg_addr),
    .data     (port_data),
    .code     (sel_code)
  );

  clkrate_divider u_div (
    .clk      (clk),
    .rst      (rst),
    .code     (sel_code),
    .cnt      (div_cnt),
    .tick_out (rate_clk)
  );
endmodule

// File: rtl/clkrate_gen_chk.sv
module clkrate_gen_chk
  import clkrate_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             rate_clk,
  input logic [CNT_W-1:0] cnt,
  input logic [SEL_W-1:0] sel,
  input logic             wr_pulse
);
  localparam logic [CNT_W-1:0] MAX_RELOAD = CNT_W'(reload_of(3'b111));

  a_r1_reset_state: assert property (@(negedge clk) disable iff (rst)
    $past(rst) |-> (rate_clk == 1'b0) && (sel == RESET_CODE));

  a_r2_reload_value: assert property (@(negedge clk) disable iff (rst)
    (cnt == '0) |=> (cnt == CNT_W'(reload_of($past(sel)))));

  a_r3_cnt_bound: assert property (@(negedge clk) disable iff (rst)
    cnt <= MAX_RELOAD);

  a_r4_hold_nonzero: assert property (@(negedge clk) disable iff (rst)
    (cnt != '0) |=> $stable(rate_clk) && (cnt == $past(cnt) - 1'b1));

  a_r4_flip_at_zero: assert property (@(negedge clk) disable iff (rst)
    (cnt == '0) |=> (rate_clk != $past(rate_clk)));

  a_r6_sel_hold: assert property (@(negedge clk) disable iff (rst)
    !wr_pulse |=> $stable(sel));
endmodule

bind clkrate_gen clkrate_gen_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .rate_clk (rate_clk),
  .cnt      (div_cnt),
  .sel      (sel_code),
  .wr_pulse (wr_pulse)
);

// File: tb/clkrate_gen_test.sv
module clkrate_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] port_data = '0;
  logic [1:0] reg_addr = '0;
  logic       reg_strobe = 1'b0;
  logic       rate_clk;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  clkrate_gen uut (
    .clk        (clk),
    .rst        (rst),
    .port_data  (port_data),
    .reg_addr   (reg_addr),
    .reg_strobe (reg_strobe),
    .rate_clk   (rate_clk)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Waits for a transition of rate_clk, then counts cycles to the next one.
  task automatic measure_half(output int n);
    logic prev;
    prev = rate_clk;
    do @(posedge clk); while (rate_clk == prev);
    prev = rate_clk;
    n = 0;
    do begin @(posedge clk); n++; end while (rate_clk == prev);
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [3:0] d);
    @(posedge clk);
    reg_addr = a; port_data = d; reg_strobe = 1'b1;
    repeat (4) @(posedge clk);
    reg_strobe = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  task automatic t_reset;
    int n;
    rst = 1'b1;
    repeat (5) @(posedge clk);
    check("R1 output low in reset", int'(rate_clk), 0);
    rst = 1'b0;
    @(posedge clk);
    check("R1 first toggle after release", int'(rate_clk), 1);
    measure_half(n);
    check("R1 default half-period", n, 20);
  endtask

  task automatic t_codes;
    int n, m;
    int exp_half [5] = '{1, 2, 5, 10, 20};
    for (int c = 0; c < 5; c++) begin
      write_reg(2'b01, 4'(c));
      measure_half(n);
      measure_half(m);
      check($sformatf("R2 code %0d half", c), n, exp_half[c]);
      check($sformatf("R4 code %0d equal halves", c), m, n);
    end
  endtask

  task automatic t_saturate;
    int n;
    for (int c = 5; c < 8; c++) begin
      write_reg(2'b01, 4'(c));
      measure_half(n);
      check($sformatf("R3 code %0d half", c), n, 50);
    end
  endtask

  task automatic t_wrong_addr;
    int n;
    write_reg(2'b01, 4'b0011);
    write_reg(2'b00, 4'b0000);
    write_reg(2'b10, 4'b0000);
    write_reg(2'b11, 4'b0000);
    measure_half(n);
    check("R6 other addresses ignored", n, 10);
  endtask

  task automatic t_high_bit;
    int n;
    write_reg(2'b01, 4'b1001);
    measure_half(n);
    check("R7 bit 3 ignored", n, 2);
  endtask

  task automatic t_level_strobe;
    int n;
    @(posedge clk);
    reg_addr = 2'b01; port_data = 4'b0011; reg_strobe = 1'b1;
    repeat (5) @(posedge clk);
    port_data = 4'b0000;
    repeat (8) @(posedge clk);
    measure_half(n);
    check("R5 held strobe no rewrite", n, 10);
    reg_strobe = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  task automatic t_mid_switch;
    int n, m;
    logic prev;
    write_reg(2'b01, 4'b0100);
    prev = rate_clk;
    do @(posedge clk); while (rate_clk == prev);
    prev = rate_clk;
    n = 0;
    do begin
      @(posedge clk);
      n++;
      if (n == 3) begin reg_addr = 2'b01; port_data = 4'b0000; reg_strobe = 1'b1; end
      if (n == 8) reg_strobe = 1'b0;
    end while (rate_clk == prev);
    check("R8 running half keeps old length", n, 20);
    measure_half(m);
    check("R8 next half at new rate", m, 1);
  endtask

  initial begin
    t_reset();
    t_codes();
    t_saturate();
    t_wrong_addr();
    t_high_bit();
    t_level_strobe();
    t_mid_switch();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule